// File: doc/BRIEF.md
# Sampling Front-End Command Controller

This block receives one-byte command codes, each paired with a one-byte payload, and turns them into the settings of a two-channel sampling front end. Two of the commands pick the input range of one channel. The range value is translated into a 3-bit selector code, and that code is written into the channel's own field of a shared control byte. The other commands load a sample-rate code, request the start of a capture, or set how many channels are captured. The rate code, the start request and the channel count are passed on to the capture engine.

Every command that is accepted, valid or not, first produces a one-cycle stop pulse for the capture engine. It also switches a two-pin status LED to red and loads a countdown measured in ticks. A parameterised prescaler makes those ticks from the clock and toggles a test output on each one. When the countdown expires the LED turns off. A start request switches the LED to green and cancels the countdown, so green stays lit.

A command takes two cycles: an accept cycle and an apply cycle. During the apply cycle a busy output holds off any new strobe.

Top module: `scope_cmd_ctrl`

## Requirements
- R1: After reset, `ctrl_byte` is 0x48 (both range fields hold code 010), `rate_code` is 1, `chan_count` is 2, both LED pins are high, `cmd_busy` is low, and the `cap_start`, `cap_stop` and `cmd_unhandled` pulses are low.
- R2: Command 0xE0 sets `ctrl_byte[4:2]` and command 0xE1 sets `ctrl_byte[7:5]`. The payload maps to a code as follows: 1 gives 010, 2 gives 001, 5 gives 000 and 10 gives 011. All other bits of `ctrl_byte` keep their value, and bits 1:0 are always 0.
- R3: A range command whose payload is not 1, 2, 5 or 10 leaves `ctrl_byte` unchanged. `ctrl_byte` changes only in the cycle after a command is accepted.
- R4: Every accepted command raises `cap_stop` for exactly one cycle, in the cycle after the strobe is sampled. In that same cycle the LED becomes red: `led_a`=0 and `led_b`=1.
- R5: An accepted command loads a countdown of `LED_TICKS` ticks. The LED stays red through `LED_TICKS`-1 ticks and turns off (both pins high) on tick number `LED_TICKS`.
- R6: Command 0xE3 with payload 1 raises `cap_start` for one cycle, two cycles after the strobe is sampled. At the same time the LED becomes green (`led_a`=1, `led_b`=0) and the LED then stays green as ticks pass. Command 0xE3 with any other payload does not raise `cap_start`.
- R7: Command 0xE2 loads its payload into `rate_code`.
- R8: Command 0xE4 loads `chan_count` only when the payload is 1 or 2. Any other payload leaves `chan_count` unchanged.
- R9: A command code below 0xE0 or above 0xE4 raises `cmd_unhandled` for one cycle in the apply cycle and changes no setting.
- R10: `cmd_busy` is high in the cycle after a strobe is accepted. A strobe presented while busy is high is ignored.
- R11: One tick occurs every `TICK_DIV` clock cycles, and `tick_toggle` inverts on each tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| cmd_arg | input | 8 | Payload byte |
| cmd_busy | output | 1 | High while a command is being applied; a strobe is ignored while it is high |
| cmd_unhandled | output | 1 | One-cycle pulse for an unknown command code |
| ctrl_byte | output | 8 | Shared control byte holding the range fields |
| led_a | output | 1 | LED pin 0 |
| led_b | output | 1 | LED pin 1 |
| tick_toggle | output | 1 | Inverts on each tick |
| cap_stop | output | 1 | One-cycle capture abort pulse |
| cap_start | output | 1 | One-cycle capture start pulse |
| rate_code | output | 8 | Sample-rate code |
| chan_count | output | 2 | Channel count (1 or 2) |

## Verification
Most internal errors show up on the ports within two cycles of a strobe. A wrong code or field offset corrupts `ctrl_byte` one cycle after the stop pulse. A sequencer that skips or repeats the apply cycle shows as a missing or doubled stop, start or unhandled pulse, or as a missed hold-off. A fault in the countdown is visible only at expiry: the LED then turns off one tick early or late, or never, or stays red after a start. For that reason the bench counts `tick_toggle` edges to find the exact tick where the LED should turn off.

// File: rtl/scope_cmd_pkg.sv
// Package: shared command codes, field geometry and the range encoder.
// Assumes an 8-bit command path and a 3-bit range selector per channel.
package scope_cmd_pkg;

    localparam int          RANGE_W     = 3;
    localparam int          FIELD_BASE  = 2;
    localparam logic [7:0]  CMD_RANGE0  = 8'hE0;
    localparam logic [7:0]  CMD_RATE    = 8'hE2;
    localparam logic [7:0]  CMD_RUN     = 8'hE3;
    localparam logic [7:0]  CMD_CHANS   = 8'hE4;
    localparam logic [7:0]  CMD_FIRST   = 8'hE0;
    localparam logic [7:0]  CMD_LAST    = 8'hE4;
    localparam logic [RANGE_W-1:0] RANGE_RST = 3'b010;

    typedef enum logic {ST_IDLE, ST_APPLY} seq_state_t;

    // Map a range payload to its selector code; MSB of the result is the valid flag.
    function automatic logic [RANGE_W:0] encode_range(input logic [7:0] val);
        case (val)
            8'd1:    encode_range = {1'b1, 3'b010};
            8'd2:    encode_range = {1'b1, 3'b001};
            8'd5:    encode_range = {1'b1, 3'b000};
            8'd10:   encode_range = {1'b1, 3'b011};
            default: encode_range = {1'b0, 3'b000};
        endcase
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
// Tick prescaler: produces a one-cycle tick every DIV clocks and a test
// output that inverts on each tick. Assumes DIV >= 2.
module tick_prescaler #(
    parameter int DIV = 500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic tick_toggle
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    // Free-running divider count.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // Test output flip per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    tick_toggle <= 1'b0;
        else if (tick) tick_toggle <= ~tick_toggle;
    end

    p_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    p_toggle_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (tick_toggle != $past(tick_toggle)));

endmodule

// File: rtl/range_field.sv
// One channel's range field: on a matching apply, stores the encoded payload
// if it is a legal range value, otherwise keeps the stored code.
module range_field
    import scope_cmd_pkg::*;
#(
    parameter logic [7:0] MY_CODE = 8'hE0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               apply,
    input  logic [7:0]         code,
    input  logic [7:0]         arg,
    output logic [RANGE_W-1:0] bits
);
    logic [RANGE_W:0] enc;

    assign enc = encode_range(arg);

    // Field register update on a legal range command for this channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bits <= RANGE_RST;
        else if (apply && code == MY_CODE && enc[RANGE_W])
            bits <= enc[RANGE_W-1:0];
    end

    p_field_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(apply && code == MY_CODE) |=> $stable(bits));

endmodule

// File: rtl/led_timer.sv
// Status LED with timed red: a load sets red and arms the countdown, green
// cancels it, and each tick counts down; expiry switches both pins high.
module led_timer #(
    parameter int LED_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load_red,
    input  logic set_green,
    output logic led_a,
    output logic led_b
);
    localparam int LW = $clog2(LED_TICKS + 1);
    localparam logic [LW-1:0] LOAD_VAL = LW'(LED_TICKS);

    logic [LW-1:0] cnt_q;

    // Countdown and LED pin state; load wins over green, green over tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            led_a <= 1'b1;
            led_b <= 1'b1;
        end else if (load_red) begin
            cnt_q <= LOAD_VAL;
            led_a <= 1'b0;
            led_b <= 1'b1;
        end else if (set_green) begin
            cnt_q <= '0;
            led_a <= 1'b1;
            led_b <= 1'b0;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == LW'(1)) begin
                led_a <= 1'b1;
                led_b <= 1'b1;
            end
        end
    end

    p_red_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_red |=> (!led_a && led_b));
    p_off_at_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == LW'(1) && !load_red && !set_green) |=> (led_a && led_b));
    p_green_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (led_a && !led_b && !load_red) |=> (led_a && !led_b));

endmodule

// File: rtl/scope_cmd_ctrl.sv
// Command controller top: accepts a strobe when idle (stop pulse, red LED),
// applies the command one cycle later, and holds off strobes meanwhile.
// Assumes the command byte and payload are stable in the strobe cycle.
module scope_cmd_ctrl
    import scope_cmd_pkg::*;
#(
    parameter int TICK_DIV  = 500,
    parameter int LED_TICKS = 1000,
    parameter int NUM_CH    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  logic [7:0] cmd_arg,
    output logic       cmd_busy,
    output logic       cmd_unhandled,
    output logic [7:0] ctrl_byte,
    output logic       led_a,
    output logic       led_b,
    output logic       tick_toggle,
    output logic       cap_stop,
    output logic       cap_start,
    output logic [7:0] rate_code,
    output logic [1:0] chan_count
);
    localparam int CTRL_W = FIELD_BASE + NUM_CH * RANGE_W;

    seq_state_t  state_q;
    logic [7:0]  code_q;
    logic [7:0]  arg_q;
    logic        accept;
    logic        apply;
    logic        run_ok;
    logic        tick;
    logic [CTRL_W-1:0] ctrl_w;

    assign accept   = (state_q == ST_IDLE) && cmd_valid;
    assign apply    = (state_q == ST_APPLY);
    assign run_ok   = apply && code_q == CMD_RUN && arg_q == 8'd1;
    assign cmd_busy = apply;

    // Sequencer: latch the command on accept, apply it in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            code_q   <= '0;
            arg_q    <= '0;
            cap_stop <= 1'b0;
        end else begin
            cap_stop <= accept;
            if (accept) begin
                code_q  <= cmd_code;
                arg_q   <= cmd_arg;
                state_q <= ST_APPLY;
            end else if (apply) begin
                state_q <= ST_IDLE;
            end
        end
    end

    // Forwarded capture settings and one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_code     <= 8'd1;
            chan_count    <= 2'd2;
            cap_start     <= 1'b0;
            cmd_unhandled <= 1'b0;
        end else begin
            cap_start     <= run_ok;
            cmd_unhandled <= apply && (code_q < CMD_FIRST || code_q > CMD_LAST);
            if (apply && code_q == CMD_RATE)
                rate_code <= arg_q;
            if (apply && code_q == CMD_CHANS && (arg_q == 8'd1 || arg_q == 8'd2))
                chan_count <= arg_q[1:0];
        end
    end

    assign ctrl_w[FIELD_BASE-1:0] = '0;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_field
            range_field #(
                .MY_CODE(CMD_RANGE0 + 8'(ch))
            ) field_i (
                .clk  (clk),
                .rst_n(rst_n),
                .apply(apply),
                .code (code_q),
                .arg  (arg_q),
                .bits (ctrl_w[FIELD_BASE + ch*RANGE_W +: RANGE_W])
            );
        end
    endgenerate

    assign ctrl_byte = 8'(ctrl_w);

    tick_prescaler #(.DIV(TICK_DIV)) presc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .tick_toggle(tick_toggle)
    );

    led_timer #(.LED_TICKS(LED_TICKS)) led_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load_red (accept),
        .set_green(run_ok),
        .led_a    (led_a),
        .led_b    (led_b)
    );

    p_ctrl_only_on_apply_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_APPLY) |=> $stable(ctrl_byte));
    p_stop_with_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stop |-> cmd_busy);
    p_stop_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stop |=> !cap_stop);
    p_unhandled_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_unhandled |-> !cap_start);

endmodule

// File: tb/scope_cmd_ctrl_tb_top.sv
// Bench: vector table of commands with expected settings, then directed tests
// for reset, LED countdown, tick spacing, green hold and busy hold-off.
module scope_cmd_ctrl_tb_top;
    localparam int TDIV = 4;
    localparam int LTK  = 6;
    localparam int NV   = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = '0;
    logic [7:0] cmd_arg = '0;
    logic       cmd_busy, cmd_unhandled, led_a, led_b, tick_toggle, cap_stop, cap_start;
    logic [7:0] ctrl_byte, rate_code;
    logic [1:0] chan_count;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scope_cmd_ctrl #(.TICK_DIV(TDIV), .LED_TICKS(LTK), .NUM_CH(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_arg(cmd_arg), .cmd_busy(cmd_busy), .cmd_unhandled(cmd_unhandled),
        .ctrl_byte(ctrl_byte), .led_a(led_a), .led_b(led_b),
        .tick_toggle(tick_toggle), .cap_stop(cap_stop), .cap_start(cap_start),
        .rate_code(rate_code), .chan_count(chan_count)
    );

    // Vector: code, arg, exp ctrl, exp rate, exp count, exp start, exp unhandled.
    localparam logic [35:0] VEC [NV] = '{
        {8'hE0, 8'd2,  8'h44, 8'h01, 2'd2, 1'b0, 1'b0},
        {8'hE1, 8'd10, 8'h64, 8'h01, 2'd2, 1'b0, 1'b0},
        {8'hE0, 8'd5,  8'h60, 8'h01, 2'd2, 1'b0, 1'b0},
        {8'hE1, 8'd7,  8'h60, 8'h01, 2'd2, 1'b0, 1'b0},
        {8'hE0, 8'd10, 8'h6C, 8'h01, 2'd2, 1'b0, 1'b0},
        {8'hE1, 8'd1,  8'h4C, 8'h01, 2'd2, 1'b0, 1'b0},
        {8'hE2, 8'h30, 8'h4C, 8'h30, 2'd2, 1'b0, 1'b0},
        {8'hE4, 8'd1,  8'h4C, 8'h30, 2'd1, 1'b0, 1'b0},
        {8'hE4, 8'd3,  8'h4C, 8'h30, 2'd1, 1'b0, 1'b0},
        {8'hE4, 8'd2,  8'h4C, 8'h30, 2'd2, 1'b0, 1'b0},
        {8'hE3, 8'd0,  8'h4C, 8'h30, 2'd2, 1'b0, 1'b0},
        {8'hE3, 8'd1,  8'h4C, 8'h30, 2'd2, 1'b1, 1'b0},
        {8'h55, 8'd0,  8'h4C, 8'h30, 2'd2, 1'b0, 1'b1},
        {8'hE5, 8'd1,  8'h4C, 8'h30, 2'd2, 1'b0, 1'b1},
        {8'hDF, 8'd1,  8'h4C, 8'h30, 2'd2, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Strobe one command; returns after the apply result is visible.
    task automatic send(input logic [7:0] c, input logic [7:0] a, input bit chk);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c; cmd_arg = a;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (chk) begin
            check("R4 stop pulse", {31'd0, cap_stop}, 32'd1);
            check("R4 led red", {30'd0, led_a, led_b}, 32'b01);
            check("R10 busy", {31'd0, cmd_busy}, 32'd1);
        end
        @(negedge clk);
    endtask

    // Wait for the given number of tick_toggle changes, sampling at negedges.
    task automatic wait_ticks(input int n, output int gap);
        logic prev = tick_toggle;
        int seen = 0;
        int cyc = 0;
        gap = 0;
        while (seen < n) begin
            @(negedge clk);
            cyc++;
            if (tick_toggle != prev) begin
                seen++;
                prev = tick_toggle;
                gap = cyc;
                cyc = 0;
            end
        end
    endtask

    initial begin
        int gap;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ctrl", {24'd0, ctrl_byte}, 32'h48);
        check("R1 rate", {24'd0, rate_code}, 32'd1);
        check("R1 count", {30'd0, chan_count}, 32'd2);
        check("R1 led off", {30'd0, led_a, led_b}, 32'b11);
        check("R1 pulses/busy", {28'd0, cmd_busy, cap_start, cap_stop, cmd_unhandled}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk (R2, R3, R6, R7, R8, R9)
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][35:28], VEC[i][27:20], 1'b1);
            check("R2/R3 ctrl", {24'd0, ctrl_byte}, {24'd0, VEC[i][19:12]});
            check("R7 rate", {24'd0, rate_code}, {24'd0, VEC[i][11:4]});
            check("R8 count", {30'd0, chan_count}, {30'd0, VEC[i][3:2]});
            check("R6 start", {31'd0, cap_start}, {31'd0, VEC[i][1]});
            check("R9 unhandled", {31'd0, cmd_unhandled}, {31'd0, VEC[i][0]});
            check("R4 stop single", {31'd0, cap_stop}, 32'd0);
            check("R6 led colour", {30'd0, led_a, led_b}, VEC[i][1] ? 32'b10 : 32'b01);
            @(negedge clk);
            check("R6/R9 pulse one cycle", {30'd0, cap_start, cmd_unhandled}, 32'd0);
        end

        // R5 countdown: red through LTK-1 ticks, off at tick LTK; R11 spacing
        send(8'hE2, 8'h05, 1'b1);
        check("R7 rate 5", {24'd0, rate_code}, 32'h05);
        wait_ticks(1, gap);
        wait_ticks(LTK - 3, gap);
        check("R11 tick period", gap, TDIV);
        check("R5 red before expiry", {30'd0, led_a, led_b}, 32'b01);
        wait_ticks(1, gap);
        check("R5 off at expiry", {30'd0, led_a, led_b}, 32'b11);
        wait_ticks(2, gap);
        check("R5 stays off", {30'd0, led_a, led_b}, 32'b11);

        // R6 green holds past the would-be expiry
        send(8'hE3, 8'h01, 1'b0);
        check("R6 green", {30'd0, led_a, led_b}, 32'b10);
        wait_ticks(LTK + 2, gap);
        check("R6 green held", {30'd0, led_a, led_b}, 32'b10);

        // R10 hold-off: strobe kept high with a new payload during busy
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 8'hE2; cmd_arg = 8'h11;
        @(negedge clk);
        check("R10 busy", {31'd0, cmd_busy}, 32'd1);
        cmd_arg = 8'h22;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R10 first applied", {24'd0, rate_code}, 32'h11);
        @(negedge clk);
        check("R10 second ignored", {24'd0, rate_code}, 32'h11);
        check("R10 no extra stop", {31'd0, cap_stop}, 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule